// File: doc/BRIEF.md
# Bridge Abort and Error Responder

This block sits beside the forwarding path of a two-port bus bridge. When a transaction that the bridge forwarded to the far side completes, the block chooses how the requesting master is answered. A normal completion passes the returned data through. A completion that ended in a master-abort is handled according to a mode bit. In one mode the block completes quietly: reads return all-ones data sized to the requester's bus width, and write data is dropped. In the other mode it propagates the abort to the requester. In that mode a posted write cannot be answered any more, because the requester has already finished it, so the block raises a primary system error instead.

The block also gates error reporting from the secondary side toward the primary side. A secondary system-error strobe produces the primary system-error pulse only when both of its enables are set. Secondary address and data parity-error strobes are reported only when parity response is enabled. Parity over the response data is always generated, whatever the reporting setting.

The four control bits are loaded through a single write strobe and clear to zero on reset. Every output is registered, one clock after the inputs that cause it.

Top module: `abort_err_resp`

## Requirements
- R1: After reset all four control bits are zero. All outputs are low, an aborted read completes in quiet mode, and a secondary system error raises no primary pulse.
- R2: With the abort-mode bit (cfgWrData[3]) clear, an aborted read (cplKind 2'b00, or the spare code 2'b11) responds with code 2'b10. For a narrow requester the data is ones in bits 31:0 and zeros above; when reqWide is high all 64 bits are one.
- R3: With the abort-mode bit clear, an aborted write (cplKind 2'b01 non-posted or 2'b10 posted) responds with code 2'b10, wrDiscard high and zero data.
- R4: With the abort-mode bit set, an aborted read or non-posted write responds with code 2'b01 (master-abort) and zero data.
- R5: With the abort-mode bit set, an aborted posted write produces no response. It raises priSerr only if the primary error enable (cfgWrData[2]) is set.
- R6: secSerr raises priSerr only when both the secondary forwarding enable (cfgWrData[1]) and the primary error enable are set.
- R7: priSerr is a one-cycle registered pulse, one cycle after the triggering cycle. Two triggers in the same cycle give a single pulse.
- R8: secAddrPerr or secDataPerr raises parErrRpt one cycle later only when the parity response enable (cfgWrData[0]) is set. Otherwise the strobes are ignored.
- R9: rspParity always equals the XOR of all bits of rspData.
- R10: A completion without abort responds with code 2'b00 and the forwarded data. The upper 32 bits are zero unless reqWide is high, and wrDiscard stays low.
- R11: rspValid goes high exactly one cycle after an answered completion. Response code, data and wrDiscard are zero while rspValid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Load strobe for the control bits |
| cfgWrData | input | 4 | Control bits: [3] abort mode, [2] primary error enable, [1] secondary forwarding enable, [0] parity response enable |
| cplValid | input | 1 | Far-side completion present this cycle |
| cplAbort | input | 1 | Far-side completion ended in master-abort |
| cplKind | input | 2 | 00 read, 01 non-posted write, 10 posted write, 11 treated as read |
| reqWide | input | 1 | Requester negotiated a 64-bit transfer |
| fwdData | input | 64 | Data returned by the far side |
| secSerr | input | 1 | Secondary system-error strobe |
| secAddrPerr | input | 1 | Secondary address parity-error strobe |
| secDataPerr | input | 1 | Secondary data parity-error strobe |
| rspValid | output | 1 | Response to requester valid |
| rspCode | output | 2 | 00 normal, 01 master-abort, 10 substituted or discarded |
| rspData | output | 64 | Response data |
| rspParity | output | 1 | Even parity over rspData |
| wrDiscard | output | 1 | Write data was dropped |
| priSerr | output | 1 | Primary system-error pulse |
| parErrRpt | output | 1 | Secondary parity error reported |

## Verification
Every result of this block is due exactly one clock after the cycle that caused it. This holds for the response fields, the parity bit, the system-error pulse and the parity report. A control write changes behaviour only from the following cycle on. The bench therefore drives a cycle's inputs after a falling edge and computes the expected outputs from those inputs and its own copy of the control bits. It updates that copy only after the prediction, then compares all outputs at the next falling edge. A cycle with no stimulus is also compared, which catches pulses that last longer than one cycle and responses that stay high.

// File: rtl/abort_err_pkg.sv
package abort_err_pkg;
  localparam int CFG_W = 4;
  localparam int CFG_PAR = 0;
  localparam int CFG_FWD = 1;
  localparam int CFG_PRI = 2;
  localparam int CFG_MODE = 3;

  typedef enum logic [1:0] {
    CPL_OK     = 2'b00,
    CPL_MABORT = 2'b01,
    CPL_SUBST  = 2'b10
  } cplCode_e;

  typedef enum logic [1:0] {
    K_READ = 2'b00,
    K_NPWR = 2'b01,
    K_PWR  = 2'b10,
    K_RSVD = 2'b11
  } txKind_e;

  typedef struct packed {
    logic take;
    logic fillOnes;
    logic passData;
  } dpStrobe_t;
endpackage

// File: rtl/abort_err_ctrl.sv
module abort_err_ctrl
  import abort_err_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  input  logic             cplValid,
  input  logic             cplAbort,
  input  logic [1:0]       cplKind,
  input  logic             secSerr,
  input  logic             secAddrPerr,
  input  logic             secDataPerr,
  output dpStrobe_t        dpStb,
  output logic             rspValid,
  output logic [1:0]       rspCode,
  output logic             wrDiscard,
  output logic             priSerr,
  output logic             parErrRpt
);
  logic [CFG_W-1:0] cfgQ;
  logic abortMode, priEn, fwdEn, parEn;
  logic isRead, isPosted;
  logic validD, discD, serrD, perrD;
  cplCode_e codeD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgQ <= '0;
    else if (cfgWrEn) cfgQ <= cfgWrData;
  end

  assign abortMode = cfgQ[CFG_MODE];
  assign priEn     = cfgQ[CFG_PRI];
  assign fwdEn     = cfgQ[CFG_FWD];
  assign parEn     = cfgQ[CFG_PAR];
  assign isRead    = (cplKind == K_READ) || (cplKind == K_RSVD);
  assign isPosted  = (cplKind == K_PWR);

  always_comb begin
    dpStb  = '0;
    validD = 1'b0;
    discD  = 1'b0;
    codeD  = CPL_OK;
    if (cplValid) begin
      if (!cplAbort) begin
        validD         = 1'b1;
        dpStb.take     = 1'b1;
        dpStb.passData = 1'b1;
      end else if (!abortMode) begin
        validD     = 1'b1;
        codeD      = CPL_SUBST;
        dpStb.take = 1'b1;
        if (isRead) dpStb.fillOnes = 1'b1;
        else discD = 1'b1;
      end else if (!isPosted) begin
        validD     = 1'b1;
        codeD      = CPL_MABORT;
        dpStb.take = 1'b1;
      end
    end
  end

  assign serrD = priEn & ((secSerr & fwdEn) |
                          (cplValid & cplAbort & isPosted & abortMode));
  assign perrD = parEn & (secAddrPerr | secDataPerr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid  <= 1'b0;
      rspCode   <= CPL_OK;
      wrDiscard <= 1'b0;
      priSerr   <= 1'b0;
      parErrRpt <= 1'b0;
    end else begin
      rspValid  <= validD;
      rspCode   <= codeD;
      wrDiscard <= discD;
      priSerr   <= serrD;
      parErrRpt <= perrD;
    end
  end
endmodule

// File: rtl/abort_err_dpath.sv
module abort_err_dpath
  import abort_err_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         dpStb,
  input  logic              reqWide,
  input  logic [DATA_W-1:0] fwdData,
  output logic [DATA_W-1:0] rspData,
  output logic              rspParity
);
  localparam int LANES = DATA_W / NARROW_W;

  logic [LANES-1:0]  laneOn;
  logic [DATA_W-1:0] dataD;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g == 0) begin : g_base
      assign laneOn[g] = 1'b1;
    end else begin : g_upper
      assign laneOn[g] = reqWide;
    end
    always_comb begin
      if (!dpStb.take || !laneOn[g])
        dataD[g*NARROW_W +: NARROW_W] = '0;
      else if (dpStb.fillOnes)
        dataD[g*NARROW_W +: NARROW_W] = '1;
      else if (dpStb.passData)
        dataD[g*NARROW_W +: NARROW_W] = fwdData[g*NARROW_W +: NARROW_W];
      else
        dataD[g*NARROW_W +: NARROW_W] = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspData   <= '0;
      rspParity <= 1'b0;
    end else begin
      rspData   <= dataD;
      rspParity <= ^dataD;
    end
  end
endmodule

// File: rtl/abort_err_resp.sv
module abort_err_resp
  import abort_err_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [3:0]        cfgWrData,
  input  logic              cplValid,
  input  logic              cplAbort,
  input  logic [1:0]        cplKind,
  input  logic              reqWide,
  input  logic [DATA_W-1:0] fwdData,
  input  logic              secSerr,
  input  logic              secAddrPerr,
  input  logic              secDataPerr,
  output logic              rspValid,
  output logic [1:0]        rspCode,
  output logic [DATA_W-1:0] rspData,
  output logic              rspParity,
  output logic              wrDiscard,
  output logic              priSerr,
  output logic              parErrRpt
);
  dpStrobe_t dpStb;

  abort_err_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cplValid(cplValid), .cplAbort(cplAbort), .cplKind(cplKind),
    .secSerr(secSerr), .secAddrPerr(secAddrPerr), .secDataPerr(secDataPerr),
    .dpStb(dpStb), .rspValid(rspValid), .rspCode(rspCode),
    .wrDiscard(wrDiscard), .priSerr(priSerr), .parErrRpt(parErrRpt)
  );

  abort_err_dpath #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_dpath (
    .clk(clk), .rstN(rstN), .dpStb(dpStb), .reqWide(reqWide),
    .fwdData(fwdData), .rspData(rspData), .rspParity(rspParity)
  );
endmodule

// File: rtl/abort_err_chk.sv
module abort_err_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgWrEn,
  input logic [3:0]        cfgWrData,
  input logic              cplValid,
  input logic              cplAbort,
  input logic [1:0]        cplKind,
  input logic              secSerr,
  input logic              secAddrPerr,
  input logic              secDataPerr,
  input logic              rspValid,
  input logic [1:0]        rspCode,
  input logic [DATA_W-1:0] rspData,
  input logic              rspParity,
  input logic              wrDiscard,
  input logic              priSerr,
  input logic              parErrRpt
);
  logic [3:0] shCfg;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shCfg <= '0;
    else if (cfgWrEn) shCfg <= cfgWrData;
  end

  logic postedAbort;
  assign postedAbort = cplValid && cplAbort && (cplKind == 2'b10);

  p_rsp_origin_r11: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(cplValid));

  p_mabort_code_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cplValid && cplAbort && shCfg[3] && (cplKind != 2'b10))
      |=> (rspValid && rspCode == 2'b01 && rspData == '0));

  p_discard_code_r3: assert property (@(posedge clk) disable iff (!rstN)
    wrDiscard |-> (rspValid && rspCode == 2'b10 && rspData == '0));

  p_posted_serr_r5: assert property (@(posedge clk) disable iff (!rstN)
    (postedAbort && shCfg[3] && shCfg[2]) |=> priSerr);

  p_serr_fwd_r6: assert property (@(posedge clk) disable iff (!rstN)
    (secSerr && shCfg[1] && shCfg[2]) |=> priSerr);

  p_serr_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    priSerr |-> $past(shCfg[2] && ((secSerr && shCfg[1]) ||
                                   (postedAbort && shCfg[3]))));

  p_perr_gate_r8: assert property (@(posedge clk) disable iff (!rstN)
    parErrRpt |-> $past(shCfg[0] && (secAddrPerr || secDataPerr)));

  p_parity_r9: assert property (@(posedge clk) disable iff (!rstN)
    rspParity == ^rspData);
endmodule

bind abort_err_resp abort_err_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/abort_err_resp_tb_top.sv
module abort_err_resp_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rstN, cfgWrEn, cplValid, cplAbort, reqWide;
  logic [3:0]  cfgWrData;
  logic [1:0]  cplKind;
  logic [63:0] fwdData;
  logic        secSerr, secAddrPerr, secDataPerr;
  logic        rspValid, rspParity, wrDiscard, priSerr, parErrRpt;
  logic [1:0]  rspCode;
  logic [63:0] rspData;

  abort_err_resp dut_i (.*);

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  bit [3:0]    mCfg;
  bit          expValid, expDisc, expSerr, expPerr;
  bit [1:0]    expCode;
  bit [63:0]   expData;
  string       rspTag, serrTag;

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic predict();
    bit posted, rd, postAb, secHit;
    expValid = 0; expCode = 2'b00; expData = '0; expDisc = 0; rspTag = "R11";
    posted = (cplKind == 2'b10);
    rd = (cplKind == 2'b00) || (cplKind == 2'b11);
    if (cplValid) begin
      if (!cplAbort) begin
        expValid = 1; rspTag = "R10";
        expData = reqWide ? fwdData : {32'h0, fwdData[31:0]};
      end else if (!mCfg[3]) begin
        expValid = 1; expCode = 2'b10;
        if (rd) begin
          rspTag = "R2";
          expData = reqWide ? {64{1'b1}} : {32'h0, 32'hFFFF_FFFF};
        end else begin
          rspTag = "R3"; expDisc = 1;
        end
      end else if (!posted) begin
        expValid = 1; expCode = 2'b01; rspTag = "R4";
      end else rspTag = "R5";
    end
    postAb = cplValid && cplAbort && posted && mCfg[3];
    secHit = secSerr && mCfg[1];
    expSerr = mCfg[2] && (postAb || secHit);
    serrTag = (postAb && secHit) ? "R7" : (postAb ? "R5" : "R6");
    expPerr = mCfg[0] && (secAddrPerr || secDataPerr);
    if (cfgWrEn) mCfg = cfgWrData;
  endtask

  task automatic cycle();
    predict();
    @(posedge clk);
    @(negedge clk);
    chk(rspValid == expValid, "R11", "rspValid", 64'(rspValid), 64'(expValid));
    chk(rspCode == expCode, rspTag, "rspCode", 64'(rspCode), 64'(expCode));
    chk(rspData == expData, rspTag, "rspData", rspData, expData);
    chk(wrDiscard == expDisc, rspTag, "wrDiscard", 64'(wrDiscard), 64'(expDisc));
    chk(priSerr == expSerr, serrTag, "priSerr", 64'(priSerr), 64'(expSerr));
    chk(parErrRpt == expPerr, "R8", "parErrRpt", 64'(parErrRpt), 64'(expPerr));
    chk(rspParity == ^rspData, "R9", "rspParity", 64'(rspParity), 64'(^rspData));
  endtask

  task automatic idle();
    cfgWrEn = 0; cfgWrData = '0; cplValid = 0; cplAbort = 0; cplKind = 2'b00;
    reqWide = 0; fwdData = '0; secSerr = 0; secAddrPerr = 0; secDataPerr = 0;
  endtask

  task automatic setCfg(bit [3:0] v);
    idle(); cfgWrEn = 1; cfgWrData = v; cycle(); idle();
  endtask

  task automatic cpl(bit ab, bit [1:0] k, bit w, bit [63:0] d);
    idle(); cplValid = 1; cplAbort = ab; cplKind = k; reqWide = w; fwdData = d;
    cycle(); idle();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(); rstN = 0; mCfg = '0;
    repeat (3) @(negedge clk);
    chk({rspValid, rspCode, wrDiscard, priSerr, parErrRpt} == '0, "R1",
        "outputs in reset", 64'({rspValid, rspCode, wrDiscard, priSerr, parErrRpt}), 0);
    chk(rspData == '0, "R1", "rspData in reset", rspData, 0);
    rstN = 1;
    @(negedge clk);
    // R1: defaults are all zero, so no forwarding and quiet abort mode
    idle(); secSerr = 1; secAddrPerr = 1; cycle();
    chk(priSerr == 0, "R1", "priSerr after reset", 64'(priSerr), 0);
    cpl(1, 2'b00, 0, 64'h0);
    chk(rspCode == 2'b10, "R1", "default abort mode", 64'(rspCode), 64'd2);
    // R10 normal completions
    cpl(0, 2'b00, 0, 64'hDEAD_BEEF_1234_5678);
    cpl(0, 2'b00, 1, 64'hDEAD_BEEF_1234_5678);
    cpl(0, 2'b01, 1, 64'h0F0F_0000_AAAA_5555);
    // R2 / R3 quiet mode
    cpl(1, 2'b00, 1, 64'h0);
    cpl(1, 2'b11, 0, 64'h0);
    cpl(1, 2'b01, 0, 64'h0);
    cpl(1, 2'b10, 1, 64'h0);
    // R4 / R5 propagate mode, primary enable off
    setCfg(4'b1000);
    cpl(1, 2'b00, 1, 64'h0);
    cpl(1, 2'b01, 0, 64'h0);
    cpl(1, 2'b10, 0, 64'h0);
    chk(priSerr == 0 && rspValid == 0, "R5", "posted abort without enable",
        64'({priSerr, rspValid}), 0);
    // R6 forwarding without primary enable
    setCfg(4'b0010);
    idle(); secSerr = 1; cycle();
    // all enables
    setCfg(4'b1111);
    cpl(1, 2'b10, 0, 64'h0);
    chk(priSerr == 1, "R5", "posted abort pulse", 64'(priSerr), 1);
    idle(); cycle();
    chk(priSerr == 0, "R7", "pulse one cycle", 64'(priSerr), 0);
    idle(); secSerr = 1; cycle();
    // R7 simultaneous triggers
    idle(); secSerr = 1; cplValid = 1; cplAbort = 1; cplKind = 2'b10; cycle();
    idle(); cycle();
    // R8 parity
    idle(); secDataPerr = 1; cycle();
    setCfg(4'b1110);
    idle(); secAddrPerr = 1; secDataPerr = 1; cycle();
    chk(parErrRpt == 0, "R8", "parity ignored", 64'(parErrRpt), 0);
    // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      idle();
      cfgWrEn = ($urandom_range(0, 15) == 0);
      cfgWrData = 4'($urandom());
      cplValid = $urandom_range(0, 1) == 1;
      cplAbort = $urandom_range(0, 1) == 1;
      cplKind = 2'($urandom());
      reqWide = $urandom_range(0, 1) == 1;
      fwdData = {$urandom(), $urandom()};
      secSerr = $urandom_range(0, 3) == 0;
      secAddrPerr = $urandom_range(0, 5) == 0;
      secDataPerr = $urandom_range(0, 5) == 0;
      cycle();
    end
    idle(); cycle();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule